// File: doc/BRIEF.md
# DRAM Row/Column Address Sequencer with Self-Timed Refresh

This block sits between a host and a DRAM array arranged as a square grid of rows and columns. The host presents a flat word address, a read/write flag and write data through a ready/valid handshake. The block splits the address into two halves. It places the upper half (the row) on a narrow shared address bus under a row strobe. It then places the lower half (the column) on the same bus under a column strobe, and finishes the data transfer. Read data returns on a one-cycle response pulse.

A free-running interval timer raises a refresh request. While the request is outstanding, the block stops accepting host requests. After any access in flight has finished, it runs a refresh cycle. A refresh cycle drives the next row from an internal counter under the row strobe alone. The array reads that row and writes it back. The counter steps through every row in order and wraps back to row 0. Refresh timing pays no attention to host traffic, so a host request can be held off by a refresh.

The half-address width is a parameter. One more bus pin doubles both the row range and the column range, which gives four times the words.

Top module: `dram_rc_ctrl`

## Requirements
- R1: While reset is asserted, both strobes, the write enable and the response pulse are low. After reset, the refresh row counter starts at row 0.
- R2: An accepted request first drives address bits [2*HALF_W-1:HALF_W] on the bus for T_ROW cycles. During those cycles the row strobe is high and the column strobe is low.
- R3: The row phase is followed by address bits [HALF_W-1:0] on the bus for T_COL+T_XFER cycles, with both strobes high. The column strobe never rises without the row strobe.
- R4: A write drives the data with the write enable high during the column phase. A read returns the stored word on a one-cycle response pulse right after the transfer. Writes produce no response.
- R5: The ready output is high only when no access or refresh is running and no refresh is pending. A request is accepted on a clock edge where both valid and ready are high.
- R6: The timer raises a refresh request once every REF_INTERVAL cycles after reset. A refresh cycle holds the row strobe high for T_ROW cycles, keeps the column strobe low, and starts only while a request is pending.
- R7: Successive refresh cycles drive rows 0, 1, 2 and upward in order, wrapping from the last row back to row 0.
- R8: A refresh request that arrives during a host access does not cut into that access. The refresh follows once the access has finished.
- R9: When a refresh request and a host request are both pending in the idle state, the refresh runs first.
- R10: The bus is HALF_W bits wide, so the flat address is 2*HALF_W bits and addresses 2**(2*HALF_W) words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2*HALF_W | Flat word address, row in the upper half |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | DATA_W | Read data |
| dram_addr | output | HALF_W | Shared row/column address bus |
| row_strobe | output | 1 | Row strobe, active high |
| col_strobe | output | 1 | Column strobe, active high |
| dram_we | output | 1 | Write enable to the array |
| dram_wdata | output | DATA_W | Data to the array |
| dram_rdata | input | DATA_W | Data from the array |

## Verification
The bench builds the block with HALF_W=2 and DATA_W=4, phase lengths of 2, 2 and 1 cycles, and a refresh interval of 40 cycles. With these values every one of the 16 words can be written and read back across several data patterns. The 4-row refresh counter wraps many times within one run. Refresh requests land both in idle cycles and in the middle of accesses, so the lock-out and priority rules are exercised repeatedly. A bench-side model of the interval timer predicts when a refresh becomes pending, independently of the block.

// File: rtl/dram_rc_pkg.sv
package dram_rc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ROW  = 3'd1,
        ST_COL  = 3'd2,
        ST_XFER = 3'd3,
        ST_REF  = 3'd4
    } seq_state_e;
endpackage

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
    parameter int INTERVAL = 1024
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.cnt == LAST) tmr_d.cnt = '0;
        else                   tmr_d.cnt = tmr_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign tick = (tmr_q.cnt == LAST);

    // the tick is a single-cycle pulse, once per interval
    assert_tick_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux #(
    parameter int HALF_W = 11
) (
    input  dram_rc_pkg::seq_state_e st,
    input  logic [HALF_W-1:0]       row,
    input  logic [HALF_W-1:0]       col,
    input  logic [HALF_W-1:0]       ref_row,
    output logic [HALF_W-1:0]       addr
);
    import dram_rc_pkg::*;

    always_comb begin
        unique case (st)
            ST_ROW:          addr = row;
            ST_COL, ST_XFER: addr = col;
            ST_REF:          addr = ref_row;
            default:         addr = '0;
        endcase
    end
endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm #(
    parameter int HALF_W = 11,
    parameter int DATA_W = 4,
    parameter int T_ROW  = 2,
    parameter int T_COL  = 2,
    parameter int T_XFER = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ref_tick,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic [2*HALF_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    output logic                  rsp_valid,
    output logic [DATA_W-1:0]     rsp_rdata,
    output dram_rc_pkg::seq_state_e st,
    output logic [HALF_W-1:0]     row,
    output logic [HALF_W-1:0]     col,
    output logic [HALF_W-1:0]     ref_row,
    output logic                  row_strobe,
    output logic                  col_strobe,
    output logic                  dram_we,
    output logic [DATA_W-1:0]     dram_wdata,
    input  logic [DATA_W-1:0]     dram_rdata
);
    import dram_rc_pkg::*;

    localparam int AW   = 2 * HALF_W;
    localparam int TMAX = (T_ROW > T_COL) ? ((T_ROW > T_XFER) ? T_ROW : T_XFER)
                                          : ((T_COL > T_XFER) ? T_COL : T_XFER);
    localparam int TW   = $clog2(TMAX + 1);

    typedef struct packed {
        seq_state_e         st;
        logic [TW-1:0]      cnt;
        logic               pend;
        logic [HALF_W-1:0]  row;
        logic [HALF_W-1:0]  col;
        logic [HALF_W-1:0]  ref_row;
        logic               we;
        logic [DATA_W-1:0]  wdata;
        logic [DATA_W-1:0]  rdata;
        logic               rsp;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.rsp = 1'b0;
        if (ref_tick) s_d.pend = 1'b1;
        unique case (s_q.st)
            ST_IDLE: begin
                if (s_q.pend) begin
                    s_d.st  = ST_REF;
                    s_d.cnt = TW'(T_ROW - 1);
                end else if (req_valid) begin
                    s_d.st    = ST_ROW;
                    s_d.cnt   = TW'(T_ROW - 1);
                    s_d.row   = req_addr[AW-1:HALF_W];
                    s_d.col   = req_addr[HALF_W-1:0];
                    s_d.we    = req_write;
                    s_d.wdata = req_wdata;
                end
            end
            ST_ROW: begin
                if (s_q.cnt == '0) begin
                    s_d.st  = ST_COL;
                    s_d.cnt = TW'(T_COL - 1);
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_COL: begin
                if (s_q.cnt == '0) begin
                    s_d.st  = ST_XFER;
                    s_d.cnt = TW'(T_XFER - 1);
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_XFER: begin
                if (s_q.cnt == '0) begin
                    s_d.st = ST_IDLE;
                    if (!s_q.we) begin
                        s_d.rdata = dram_rdata;
                        s_d.rsp   = 1'b1;
                    end
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_REF: begin
                if (s_q.cnt == '0) begin
                    s_d.st      = ST_IDLE;
                    s_d.ref_row = s_q.ref_row + 1'b1;
                    s_d.pend    = ref_tick;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign st         = s_q.st;
    assign row        = s_q.row;
    assign col        = s_q.col;
    assign ref_row    = s_q.ref_row;
    assign req_ready  = (s_q.st == ST_IDLE) && !s_q.pend;
    assign row_strobe = (s_q.st != ST_IDLE);
    assign col_strobe = (s_q.st == ST_COL) || (s_q.st == ST_XFER);
    assign dram_we    = col_strobe && s_q.we;
    assign dram_wdata = s_q.wdata;
    assign rsp_valid  = s_q.rsp;
    assign rsp_rdata  = s_q.rdata;

    assert_col_inside_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
        col_strobe |-> row_strobe);
    assert_ready_only_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !row_strobe);
    assert_rsp_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    assert_refrow_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_REF && s_q.cnt == '0) |=> (ref_row == HALF_W'($past(ref_row) + 1'b1)));
    assert_refresh_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_IDLE && s_q.pend) |=> (s_q.st == ST_REF));
    assert_access_unbroken_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (col_strobe && $past(col_strobe)) |-> $stable(s_q.col));
endmodule

// File: rtl/dram_rc_ctrl.sv
module dram_rc_ctrl #(
    parameter int HALF_W       = 11,
    parameter int DATA_W       = 4,
    parameter int T_ROW        = 2,
    parameter int T_COL        = 2,
    parameter int T_XFER       = 1,
    parameter int REF_INTERVAL = 1560
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [2*HALF_W-1:0] req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic [HALF_W-1:0]   dram_addr,
    output logic                row_strobe,
    output logic                col_strobe,
    output logic                dram_we,
    output logic [DATA_W-1:0]   dram_wdata,
    input  logic [DATA_W-1:0]   dram_rdata
);
    import dram_rc_pkg::*;

    logic              ref_tick;
    seq_state_e        st;
    logic [HALF_W-1:0] row, col, ref_row;

    dram_ref_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (ref_tick)
    );

    dram_seq_fsm #(
        .HALF_W(HALF_W), .DATA_W(DATA_W),
        .T_ROW(T_ROW), .T_COL(T_COL), .T_XFER(T_XFER)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_tick  (ref_tick),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .st        (st),
        .row       (row),
        .col       (col),
        .ref_row   (ref_row),
        .row_strobe(row_strobe),
        .col_strobe(col_strobe),
        .dram_we   (dram_we),
        .dram_wdata(dram_wdata),
        .dram_rdata(dram_rdata)
    );

    dram_addr_mux #(.HALF_W(HALF_W)) u_mux (
        .st     (st),
        .row    (row),
        .col    (col),
        .ref_row(ref_row),
        .addr   (dram_addr)
    );

    // the shared bus holds still within one strobe phase
    assert_row_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (row_strobe && !col_strobe && $past(row_strobe) && !$past(col_strobe))
        |-> $stable(dram_addr));
    assert_we_in_col_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dram_we |-> col_strobe);
endmodule

// File: tb/dram_rc_ctrl_tb_top.sv
module dram_rc_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HW   = 2;
    localparam int DW   = 4;
    localparam int TR   = 2;
    localparam int TC   = 2;
    localparam int TX   = 1;
    localparam int RINT = 40;
    localparam int AW   = 2 * HW;
    localparam int NW   = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, row_strobe, col_strobe, dram_we;
    logic [DW-1:0] rsp_rdata, dram_wdata, dram_rdata;
    logic [HW-1:0] dram_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_rc_ctrl #(.HALF_W(HW), .DATA_W(DW), .T_ROW(TR), .T_COL(TC),
                   .T_XFER(TX), .REF_INTERVAL(RINT)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_addr(dram_addr),
        .row_strobe(row_strobe), .col_strobe(col_strobe), .dram_we(dram_we),
        .dram_wdata(dram_wdata), .dram_rdata(dram_rdata));

    // behavioural array
    logic [DW-1:0] mem [NW];
    logic [HW-1:0] mrow;
    always @(posedge clk) begin
        if (row_strobe && !col_strobe) mrow <= dram_addr;
        if (col_strobe && dram_we) mem[{mrow, dram_addr}] <= dram_wdata;
    end
    assign dram_rdata = col_strobe ? mem[{mrow, dram_addr}] : '0;

    int n_chk = 0, n_fail = 0;
    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // posedges since reset release
    int edges = 0;
    always @(posedge clk) if (!rst_n) edges <= 0; else edges <= edges + 1;

    // monitor state
    bit prev_row = 0, kind_acc = 0, acc_armed = 0, bpend = 0;
    int nrow = 0, nboth = 0, ticks = 0, refs = 0, last_tick = -1;
    bit addr_bad = 0, col_bad = 0, order_bad = 0;
    logic [HW-1:0] exp_row = '0, exp_col = '0, exp_ref = '0;
    int bad_addr_val = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            check(!row_strobe && !col_strobe && !dram_we && !rsp_valid,
                  "R1 outputs idle in reset", {row_strobe, col_strobe, dram_we, rsp_valid}, 0);
        end else begin
            if (edges > 0 && edges % RINT == 0 && edges != last_tick) begin
                bpend = 1; ticks++; last_tick = edges;
            end
            if (row_strobe && !prev_row) begin
                kind_acc = acc_armed; acc_armed = 0;
                if (!kind_acc) begin
                    check(bpend, "R6 refresh only when pending", 0, 1);
                    bpend = 0;
                end
                nrow = 0; nboth = 0; addr_bad = 0; col_bad = 0; order_bad = 0;
            end
            if (row_strobe && !col_strobe) begin
                nrow++;
                if (nboth > 0) order_bad = 1;
                if (dram_addr != (kind_acc ? exp_row : exp_ref)) begin
                    addr_bad = 1; bad_addr_val = int'(dram_addr);
                end
            end
            if (col_strobe) begin
                nboth++;
                if (!row_strobe) order_bad = 1;
                if (dram_addr != exp_col) col_bad = 1;
            end
            if (!row_strobe && prev_row) begin
                if (kind_acc) begin
                    check(nrow == TR, "R2 row phase length", nrow, TR);
                    check(!addr_bad, "R2 R10 row half on bus", bad_addr_val, int'(exp_row));
                    check(nboth == TC + TX, "R3 R8 column phase length", nboth, TC + TX);
                    check(!col_bad && !order_bad, "R3 column half after row", col_bad, 0);
                end else begin
                    check(nrow == TR && nboth == 0, "R6 refresh strobe shape", nrow * 10 + nboth, TR * 10);
                    check(!addr_bad, "R7 refresh row order", bad_addr_val, int'(exp_ref));
                    exp_ref = exp_ref + 1'b1;
                    refs++;
                end
            end
            if (req_ready) begin
                if (bpend) check(1'b0, "R5 R9 ready while refresh pending", 1, 0);
                if (row_strobe) check(1'b0, "R5 ready while busy", 1, 0);
            end
            if (req_valid && req_ready) begin
                acc_armed = 1;
                exp_row = req_addr[AW-1:HW];
                exp_col = req_addr[HW-1:0];
            end
            prev_row = row_strobe;
        end
    end

    logic [DW-1:0] expmem [NW];

    task automatic host_op(input bit wr, input int a, input logic [DW-1:0] d);
        bit got;
        @(posedge clk); #1;
        req_valid = 1; req_write = wr; req_addr = AW'(a); req_wdata = d;
        do begin
            @(negedge clk); got = req_ready;
            @(posedge clk);
        end while (!got);
        #1 req_valid = 0;
        if (wr) begin
            expmem[a] = d;
            repeat (TR + TC + TX + 1) @(negedge clk);
            check(!rsp_valid, "R4 no response for write", rsp_valid, 0);
        end else begin
            @(negedge clk);
            while (!rsp_valid) @(negedge clk);
            check(rsp_rdata == expmem[a], "R4 read data", rsp_rdata, expmem[a]);
        end
    endtask

    bit done = 0;
    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 R5 ready after reset", req_ready, 1);
        for (int a = 0; a < NW; a++) host_op(1, a, DW'(a * 5 + 3));
        for (int a = 0; a < NW; a++) host_op(0, a, '0);
        for (int a = 0; a < NW; a++) host_op(1, a, DW'(~(a * 3)));
        for (int a = NW - 1; a >= 0; a--) host_op(0, a, '0);
        for (int a = 0; a < NW; a++) host_op(1, a, DW'(a ^ 4'hA));
        for (int a = 0; a < NW; a++) host_op(0, (a * 7) % NW, '0);
        repeat (3 * RINT) @(negedge clk);
        check(refs >= ticks - 1 && refs <= ticks && ticks >= 5,
              "R6 R7 refresh count vs interval", refs, ticks);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog R5 actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule